// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Register

This block is a single 64-bit control/status register that delivers timer interrupts and inter-processor interrupts (IPIs) to four processors. Software reaches it through a simple read/write port. Every access carries the ID of the processor making it. A periodic tick from an external timer raises a timer interrupt toward every processor. Any processor can send an IPI to any set of processors by writing ones into a request field.

Timer status is write-one-to-clear. Each timer status bit is also the level of that processor's timer interrupt line. IPI status bits are set only through the request field and cleared through their own write-one-to-clear field. Behind each IPI output sits a small pending counter, so a processor's IPI line stays high until every request sent to it has been acknowledged. A write that touches none of the three action fields is flagged as unsupported.

Top module: `ipt_misc_csr`

## Requirements
- R1: While `csr_rd` is high, `csr_rdata` equals the stored register value with the reader's ID from `csr_cpu_id` in bits 1:0; while `csr_rd` is low, `csr_rdata` is zero.
- R2: A write with bit 4+i set clears timer status bit 4+i and drops `tmr_irq[i]` on the next clock edge.
- R3: A `tick` cycle sets timer status bits 7:4 and all four `tmr_irq` lines on the next edge. If a timer-clear write arrives in the same cycle, the tick wins.
- R4: A write with bit 12+i set sets IPI status bit 8+i and asserts `ipi_irq[i]` on the next edge. Bits 15:12 always read as zero.
- R5: Each IPI request to processor i increments its pending count, and `ipi_irq[i]` is high exactly while that count is nonzero.
- R6: A write with bit 8+i set clears status bit 8+i. It decrements processor i's pending count only if the count is nonzero, and the count never wraps below zero.
- R7: The actions of one write are applied in a fixed order: timer clear, then IPI request, then IPI clear. A request and a clear for the same processor in one write therefore leave the status bit clear and the count unchanged.
- R8: A write with no bit set in 15:4 changes no state and raises `wr_err` for exactly the one cycle after the write. Any other write leaves `wr_err` low.
- R9: Reset clears all status bits, pending counts and interrupt outputs. Bits 3:2 and 63:16 ignore writes and read as zero.
- R10: A pending count saturates at 7. Further requests leave it at 7, so exactly 7 clears are needed to drop the IPI line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_wr | input | 1 | Write strobe, one cycle per write |
| csr_rd | input | 1 | Read enable |
| csr_cpu_id | input | 2 | ID of the processor making the access |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data |
| tick | input | 1 | Periodic timer tick |
| tmr_irq | output | 4 | Timer interrupt level, one bit per processor |
| ipi_irq | output | 4 | Inter-processor interrupt level, one bit per processor |
| wr_err | output | 1 | One-cycle flag for an unsupported write |

## Verification
The bench targets the pending counters. It sends several IPIs before acknowledging them, so a design that dropped the line on the first clear would be caught. It sends eight requests to one processor, so a counter that wrapped would fall silent at once. It also clears an idle processor, so an underflow would leave a phantom IPI asserted. A single write that both requests and clears the same processor exposes a wrong action order: the status bit would be left set, or the count would change. A tick that coincides with a timer clear, a write with no action bits (which must flag an error and change nothing), and writes that spray ones into reserved bits cover the remaining corners.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  localparam int NUM_CPU  = 4;
  localparam int DATA_W   = 64;
  localparam int CNT_W    = 3;
  localparam int ID_W     = $clog2(NUM_CPU);
  localparam int TMR_LSB  = 4;
  localparam int ISTS_LSB = TMR_LSB + NUM_CPU;
  localparam int IREQ_LSB = ISTS_LSB + NUM_CPU;
endpackage

// File: rtl/ipt_pend_ctr.sv
module ipt_pend_ctr #(
  parameter int CNT_W = ipt_pkg::CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic active
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_after_inc, cnt_d;
  logic             cnt_en;

  // request first, then acknowledge
  always_comb begin
    cnt_after_inc = cnt_q;
    if (inc && (cnt_q != CNT_MAX)) cnt_after_inc = cnt_q + 1'b1;
    cnt_d = cnt_after_inc;
    if (dec && (cnt_after_inc != '0)) cnt_d = cnt_after_inc - 1'b1;
    cnt_en = inc | dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));
  a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> active);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dec) |=> active);
endmodule

// File: rtl/ipt_field_ctl.sv
module ipt_field_ctl #(
  parameter int NUM_CPU = ipt_pkg::NUM_CPU,
  parameter int DATA_W  = ipt_pkg::DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               tick,
  output logic [NUM_CPU-1:0] tmr_stat,
  output logic [NUM_CPU-1:0] ipi_stat,
  output logic [NUM_CPU-1:0] ipi_req,
  output logic [NUM_CPU-1:0] ipi_ack,
  output logic               wr_err
);
  localparam int TMR_LSB  = 4;
  localparam int ISTS_LSB = TMR_LSB + NUM_CPU;
  localparam int IREQ_LSB = ISTS_LSB + NUM_CPU;

  logic [NUM_CPU-1:0] tmr_clr, tmr_d, ists_d;
  logic               tmr_en, ists_en, err_d;

  always_comb begin
    tmr_clr = wr_en ? wdata[TMR_LSB +: NUM_CPU]  : '0;
    ipi_req = wr_en ? wdata[IREQ_LSB +: NUM_CPU] : '0;
    ipi_ack = wr_en ? wdata[ISTS_LSB +: NUM_CPU] : '0;
    // timer clear, then tick raises every line not yet up
    tmr_d   = tick ? '1 : (tmr_stat & ~tmr_clr);
    tmr_en  = tick | (|tmr_clr);
    // request sets, clear applied after it
    ists_d  = (ipi_stat | ipi_req) & ~ipi_ack;
    ists_en = |(ipi_req | ipi_ack);
    err_d   = wr_en && (tmr_clr == '0) && (ipi_req == '0) && (ipi_ack == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_stat <= '0;
      ipi_stat <= '0;
      wr_err   <= 1'b0;
    end else begin
      if (tmr_en)  tmr_stat <= tmr_d;
      if (ists_en) ipi_stat <= ists_d;
      wr_err <= err_d;
    end
  end

  a_r3_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tmr_stat == '1));
  a_r2_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tick) |=> ((tmr_stat & $past(wdata[TMR_LSB +: NUM_CPU])) == '0));
  a_r7_ack_last: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ipi_stat & $past(wdata[ISTS_LSB +: NUM_CPU])) == '0));
  a_r4_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ipi_stat & $past(wdata[IREQ_LSB +: NUM_CPU] & ~wdata[ISTS_LSB +: NUM_CPU]))
               == $past(wdata[IREQ_LSB +: NUM_CPU] & ~wdata[ISTS_LSB +: NUM_CPU])));
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_err);
  a_r8_err_nochange: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tick && wdata[IREQ_LSB+NUM_CPU-1:TMR_LSB] == '0) |=>
      (wr_err && $stable(ipi_stat) && $stable(tmr_stat)));
endmodule

// File: rtl/ipt_misc_csr.sv
module ipt_misc_csr #(
  parameter int NUM_CPU = ipt_pkg::NUM_CPU,
  parameter int DATA_W  = ipt_pkg::DATA_W,
  parameter int CNT_W   = ipt_pkg::CNT_W,
  parameter int ID_W    = ipt_pkg::ID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wr,
  input  logic               csr_rd,
  input  logic [ID_W-1:0]    csr_cpu_id,
  input  logic [DATA_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0]  csr_rdata,
  input  logic               tick,
  output logic [NUM_CPU-1:0] tmr_irq,
  output logic [NUM_CPU-1:0] ipi_irq,
  output logic               wr_err
);
  localparam int TMR_LSB  = 4;
  localparam int ISTS_LSB = TMR_LSB + NUM_CPU;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_CPU-1:0] tmr_stat, ipi_stat, ipi_req, ipi_ack;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ipt_field_ctl #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_fields (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (csr_wr),
    .wdata    (csr_wdata),
    .tick     (tick),
    .tmr_stat (tmr_stat),
    .ipi_stat (ipi_stat),
    .ipi_req  (ipi_req),
    .ipi_ack  (ipi_ack),
    .wr_err   (wr_err)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_pend
    ipt_pend_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .inc    (ipi_req[g]),
      .dec    (ipi_ack[g]),
      .active (ipi_irq[g])
    );
  end

  assign tmr_irq = tmr_stat;

  always_comb begin
    csr_rdata = '0;
    if (csr_rd) begin
      csr_rdata[ID_W-1:0]              = csr_cpu_id;
      csr_rdata[TMR_LSB +: NUM_CPU]    = tmr_stat;
      csr_rdata[ISTS_LSB +: NUM_CPU]   = ipi_stat;
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !csr_rd |-> (csr_rdata == '0));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> (tmr_irq == '0 && ipi_irq == '0));
endmodule

// File: tb/ipt_misc_csr_tb_top.sv
`timescale 1ns/1ps
module ipt_misc_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr, csr_rd, tick;
  logic [1:0]  csr_cpu_id;
  logic [63:0] csr_wdata, csr_rdata;
  logic [3:0]  tmr_irq, ipi_irq;
  logic        wr_err;
  int          n_checks = 0;
  int          n_errors = 0;
  logic        last_err;

  always #5 clk = ~clk;

  ipt_misc_csr dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_cpu_id(csr_cpu_id), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .tick(tick), .tmr_irq(tmr_irq), .ipi_irq(ipi_irq), .wr_err(wr_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
    last_err = wr_err;
  endtask

  task automatic do_read(input logic [1:0] id, output logic [63:0] v);
    @(negedge clk);
    csr_rd = 1'b1; csr_cpu_id = id;
    #1 v = csr_rdata;
    csr_rd = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [63:0] v;
    check("R9 tmr_irq after reset", tmr_irq, 0);
    check("R9 ipi_irq after reset", ipi_irq, 0);
    check("R8 wr_err after reset", wr_err, 0);
    do_read(2'd2, v);
    check("R1 read id only", v, 64'h2);
    @(negedge clk);
    check("R1 idle rdata zero", csr_rdata, 0);
  endtask

  task automatic t_tick_and_clear();
    logic [63:0] v;
    do_tick();
    check("R3 tick raises all", tmr_irq, 4'hF);
    do_write(64'h20);
    check("R2 clear bit 5", tmr_irq, 4'hD);
    check("R8 supported write no err", last_err, 0);
    do_read(2'd1, v);
    check("R2 R1 read after clear", v, 64'hD1);
    do_tick();
    check("R3 tick re-raises", tmr_irq, 4'hF);
  endtask

  task automatic t_ipi_basic();
    logic [63:0] v;
    do_write(64'hA000);
    check("R4 ipi to 1 and 3", ipi_irq, 4'hA);
    do_read(2'd0, v);
    check("R4 status bits, request field reads zero", v, 64'hAF0);
  endtask

  task automatic t_pending_count();
    logic [63:0] v;
    repeat (3) do_write(64'h1000);
    check("R5 ipi0 up", ipi_irq[0], 1);
    do_write(64'h0100);
    check("R6 ipi0 held after 1 clear", ipi_irq[0], 1);
    do_read(2'd0, v);
    check("R6 status bit 8 cleared", v[8], 0);
    do_write(64'h0100);
    check("R6 ipi0 held after 2 clears", ipi_irq[0], 1);
    do_write(64'h0100);
    check("R6 ipi0 drops at zero", ipi_irq[0], 0);
    do_write(64'h0100);
    do_write(64'h1000);
    do_write(64'h0100);
    check("R6 no underflow on idle clear", ipi_irq[0], 0);
  endtask

  task automatic t_saturation();
    repeat (8) do_write(64'h4000);
    check("R10 ipi2 up after 8 requests", ipi_irq[2], 1);
    repeat (6) do_write(64'h0400);
    check("R10 ipi2 held after 6 clears", ipi_irq[2], 1);
    do_write(64'h0400);
    check("R10 ipi2 drops after 7 clears", ipi_irq[2], 0);
  endtask

  task automatic t_order();
    logic [63:0] v;
    do_write(64'h8810);
    check("R7 ipi3 still pending", ipi_irq, 4'hA);
    check("R7 timer clear in same write", tmr_irq, 4'hE);
    do_read(2'd3, v);
    check("R7 status bit 11 clear, bit 9 kept", v, 64'h2E3);
    do_write(64'h0A00);
    check("R6 ipi1 and ipi3 drop", ipi_irq, 4'h0);
  endtask

  task automatic t_unsupported();
    logic [63:0] v;
    do_write(64'hFFFF_0000_0000_000F);
    check("R8 err on empty write", last_err, 1);
    @(negedge clk);
    check("R8 err one cycle", wr_err, 0);
    check("R8 timer unchanged", tmr_irq, 4'hE);
    check("R8 ipi unchanged", ipi_irq, 4'h0);
    do_read(2'd0, v);
    check("R8 register unchanged", v, 64'hE0);
  endtask

  task automatic t_reserved();
    logic [63:0] v;
    do_write(64'hFFFF_FFFF_FFFF_00F0);
    check("R8 no err", last_err, 0);
    do_read(2'd3, v);
    check("R9 reserved bits read zero", v, 64'h3);
  endtask

  task automatic t_tick_vs_clear();
    @(negedge clk);
    tick = 1'b1; csr_wr = 1'b1; csr_wdata = 64'h30;
    @(negedge clk);
    tick = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
    check("R3 tick wins over clear", tmr_irq, 4'hF);
  endtask

  task automatic t_mid_reset();
    logic [63:0] v;
    do_write(64'h1000);
    check("R5 ipi0 before reset", ipi_irq, 4'h1);
    apply_reset();
    check("R9 tmr cleared", tmr_irq, 0);
    check("R9 ipi cleared", ipi_irq, 0);
    do_read(2'd1, v);
    check("R9 register cleared", v, 64'h1);
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    csr_wr = 0; csr_rd = 0; tick = 0; csr_cpu_id = 0; csr_wdata = 0; last_err = 0;
    apply_reset();
    t_reset_state();
    t_tick_and_clear();
    t_ipi_basic();
    t_pending_count();
    t_saturation();
    t_order();
    t_unsupported();
    t_reserved();
    t_tick_vs_clear();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule